// File: doc/BRIEF.md
# Two-Host Bridge Command Controller

This block holds the control and status registers that each of two hosts sees on its own side of a non-transparent bridge. It also runs the command handshake that sets up doorbells, memory windows and link state. Host 0 is the primary side and host 1 is the secondary side. Each host has a private register file behind a simple 32-bit word port: one write strobe, one read strobe and a word address.

A host first loads the argument, address and size words. It then writes a non-zero code to the command word. The block marks the command busy for one cycle and then either accepts it or rejects it:

- On acceptance it clears the command word, posts a success or error code in the status word, and latches the translation parameters on its outputs. Interrupt-routing logic and window-routing logic outside the block use these parameters.
- The link-up command from each host sets a sticky per-host flag. When the second host's flag joins the first, the block pulses a link event to both hosts in the same cycle.

Top module: `hostlink_cmd_ctrl`

## Requirements
- R1: After reset the following all read 0 on both hosts: the command, argument, address low/high, size and status words. The doorbell count, doorbell mode, window outputs, link-up flags and link events are also 0.
- R2: The read-write words are argument (word 1), address low (word 4), address high (word 5) and size (word 6). Each returns what its own host last wrote, independently of the other host. Read data appears one cycle after the read strobe.
- R3: The words below are constant and ignore writes:
  - word 3 reads 1 on host 0 and 2 on host 1;
  - word 7 reads the window count (4);
  - word 8 reads the first window offset (0x1000);
  - word 9 reads the scratchpad offset (0xC0);
  - word 10 reads the scratchpad count (16);
  - word 11 reads the doorbell entry size (4).
- R4: A non-zero write to the command word (word 0) sets the status word (word 2) to busy (1) for exactly one cycle. The block then clears the command word and posts success (2) or error (3).
- R5: Command 1 enables the doorbells:
  - argument bits [15:0] give the number of doorbells, N, and argument bit 16 selects the MSI-X mode;
  - on success the block drives N and the mode bit on its outputs;
  - doorbell data word i (word 12+i, i in 0..31) reads 0x00D00000 + 256×host + i when i < N, and 0 otherwise.
- R6: A doorbell command with N above 32 posts error and leaves the doorbell count, the mode bit and the data words unchanged.
- R7: Command 2 configures the memory window named by the argument word. On success the block pulses the window-update output for one cycle, with the window index, the 64-bit address {high, low} and the size.
- R8: A window command is rejected with error, with no update pulse and with the window outputs unchanged, in either of two cases: the index is not below the window count, or the size is 0.
- R9: Any command code other than 1, 2 or 3 posts error and changes no output.
- R10: Command 3 sets that host's sticky link-up flag. The link event pulses for one cycle on both hosts only in the cycle when both flags first become set; one host alone raises no event.
- R11: The link-up flags stay set until reset. Repeated link commands succeed but raise no further event.
- R12: Register writes that arrive during the busy cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 2 | Per-host write strobe |
| reg_rd | input | 2 | Per-host read strobe |
| reg_addr | input | 2x6 | Per-host word address |
| reg_wdata | input | 2x32 | Per-host write data |
| reg_rdata | output | 2x32 | Per-host read data, valid one cycle after the read strobe |
| db_count | output | 2x6 | Enabled doorbell count per host |
| db_msix | output | 2 | Doorbell mode bit per host |
| mw_upd | output | 2 | One-cycle window-update pulse per host |
| mw_index | output | 2x2 | Configured window index |
| mw_addr | output | 2x64 | Configured window target address |
| mw_size | output | 2x32 | Configured window size |
| link_up | output | 2 | Sticky per-host link-up flags |
| link_evt | output | 2 | One-cycle link event to each host |

## Verification
The bench sweeps the doorbell count from 0 through 33 on both hosts and reads every data word after each step. A count bound that is off by one would accept 33 or reject 32, and a fill bound that is wrong would show up on the word at index N. Window indices 0 through 4 are each tried with a zero and a non-zero size, which exposes an index compare that admits the window count or a missing size test. The link sequence repeats one host's command before the other host joins and repeats it again afterwards. A design that raised the event on a single host, or on every link command, therefore produces an event count other than one. A second command written during the busy cycle would, if accepted, corrupt the doorbell outputs and leave the command word non-zero.

// File: rtl/hl_pkg.sv
package hl_pkg;
    localparam int DW     = 32;
    localparam int AW     = 6;
    localparam int NHOST  = 2;
    localparam int DB_MAX = 32;
    localparam int DBC_W  = $clog2(DB_MAX + 1);

    // word map; doorbell data words follow the fixed fields
    localparam int F_CMD   = 0;
    localparam int F_ARG   = 1;
    localparam int F_STAT  = 2;
    localparam int F_TOPO  = 3;
    localparam int F_ALO   = 4;
    localparam int F_AHI   = 5;
    localparam int F_SIZE  = 6;
    localparam int F_NMW   = 7;
    localparam int F_MW1   = 8;
    localparam int F_SPOFS = 9;
    localparam int F_SPCNT = 10;
    localparam int F_DBENT = 11;
    localparam int F_DB0   = 12;

    localparam logic [DW-1:0] OP_DB   = 32'd1;
    localparam logic [DW-1:0] OP_MW   = 32'd2;
    localparam logic [DW-1:0] OP_LINK = 32'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_OK   = 2'd2,
        ST_ERR  = 2'd3
    } stat_e;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_DB   = 2'd1,
        K_MW   = 2'd2,
        K_LINK = 2'd3
    } kind_e;
endpackage

// File: rtl/hl_cmd_decode.sv
module hl_cmd_decode import hl_pkg::*; #(
    parameter int NUM_MW = 4
) (
    input  logic [DW-1:0] cmd,
    input  logic [DW-1:0] arg,
    input  logic [DW-1:0] size,
    output kind_e         kind,
    output logic          ok
);
    localparam logic [15:0] DB_LIMIT = 16'(DB_MAX);
    localparam logic [DW-1:0] MW_LIMIT = DW'(NUM_MW);

    always_comb begin
        kind = K_NONE;
        ok   = 1'b0;
        case (cmd)
            OP_DB: begin
                kind = K_DB;
                ok   = (arg[15:0] <= DB_LIMIT);
            end
            OP_MW: begin
                kind = K_MW;
                ok   = (arg < MW_LIMIT) && (size != '0);
            end
            OP_LINK: begin
                kind = K_LINK;
                ok   = 1'b1;
            end
            default: begin
                kind = K_NONE;
                ok   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/hl_host_regs.sv
module hl_host_regs import hl_pkg::*; #(
    parameter int            HOST_ID   = 0,
    parameter int            NUM_MW    = 4,
    parameter int            MW_IW     = 2,
    parameter logic [DW-1:0] TOPO_CODE = 32'd1,
    parameter logic [DW-1:0] MW1_OFS   = 32'h1000,
    parameter logic [DW-1:0] SPAD_OFS  = 32'hC0,
    parameter logic [DW-1:0] SPAD_CNT  = 32'd16,
    parameter logic [DW-1:0] DB_ENTRY  = 32'd4,
    parameter logic [DW-1:0] DB_BASE   = 32'h00D0_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic               rd,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    output logic [DBC_W-1:0]   db_count,
    output logic               db_msix,
    output logic               mw_upd,
    output logic [MW_IW-1:0]   mw_index,
    output logic [2*DW-1:0]    mw_addr,
    output logic [DW-1:0]      mw_size,
    output logic               link_req
);
    localparam logic [DW-1:0] HOST_DB_BASE = DB_BASE + DW'(HOST_ID * 256);

    typedef struct packed {
        logic [DW-1:0]    cmd;
        logic [DW-1:0]    arg;
        logic [DW-1:0]    alo;
        logic [DW-1:0]    ahi;
        logic [DW-1:0]    size;
        stat_e            st;
        logic [DBC_W-1:0] dbc;
        logic             dbx;
        logic             mwu;
        logic [MW_IW-1:0] mwi;
        logic [2*DW-1:0]  mwa;
        logic [DW-1:0]    mws;
        logic [DW-1:0]    rdat;
    } regs_t;

    regs_t q, d;
    kind_e kind;
    logic  ok;
    logic [DW-1:0] rval;
    int    ai;
    int    di;

    hl_cmd_decode #(.NUM_MW(NUM_MW)) u_dec (
        .cmd  (q.cmd),
        .arg  (q.arg),
        .size (q.size),
        .kind (kind),
        .ok   (ok)
    );

    // read mux
    always_comb begin
        ai   = int'(addr);
        di   = ai - F_DB0;
        rval = '0;
        case (ai)
            F_CMD:   rval = q.cmd;
            F_ARG:   rval = q.arg;
            F_STAT:  rval = {{(DW-2){1'b0}}, q.st};
            F_TOPO:  rval = TOPO_CODE;
            F_ALO:   rval = q.alo;
            F_AHI:   rval = q.ahi;
            F_SIZE:  rval = q.size;
            F_NMW:   rval = DW'(NUM_MW);
            F_MW1:   rval = MW1_OFS;
            F_SPOFS: rval = SPAD_OFS;
            F_SPCNT: rval = SPAD_CNT;
            F_DBENT: rval = DB_ENTRY;
            default: begin
                if (di >= 0 && di < DB_MAX && di < int'(q.dbc))
                    rval = HOST_DB_BASE + DW'(di);
            end
        endcase
    end

    // next state
    always_comb begin
        d        = q;
        d.mwu    = 1'b0;
        link_req = 1'b0;
        if (rd)
            d.rdat = rval;
        if (q.st == ST_BUSY) begin
            d.cmd = '0;
            d.st  = ok ? ST_OK : ST_ERR;
            if (ok) begin
                case (kind)
                    K_DB: begin
                        d.dbc = q.arg[DBC_W-1:0];
                        d.dbx = q.arg[16];
                    end
                    K_MW: begin
                        d.mwu = 1'b1;
                        d.mwi = q.arg[MW_IW-1:0];
                        d.mwa = {q.ahi, q.alo};
                        d.mws = q.size;
                    end
                    K_LINK:  link_req = 1'b1;
                    default: ;
                endcase
            end
        end else if (wr) begin
            case (ai)
                F_CMD: begin
                    d.cmd = wdata;
                    if (wdata != '0)
                        d.st = ST_BUSY;
                end
                F_ARG:   d.arg  = wdata;
                F_ALO:   d.alo  = wdata;
                F_AHI:   d.ahi  = wdata;
                F_SIZE:  d.size = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign rdata    = q.rdat;
    assign db_count = q.dbc;
    assign db_msix  = q.dbx;
    assign mw_upd   = q.mwu;
    assign mw_index = q.mwi;
    assign mw_addr  = q.mwa;
    assign mw_size  = q.mws;

    // R4: the busy state always resolves on the next cycle
    a_r4_busy_resolves: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == ST_BUSY |=> (q.st == ST_OK || q.st == ST_ERR) && q.cmd == '0);

    // R6: an enabled doorbell count never exceeds the supported maximum
    a_r6_db_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.dbc <= DBC_W'(DB_MAX));

    // R7: a window update is a single-cycle pulse
    a_r7_mw_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.mwu |=> !q.mwu);

    // R8: a published window has a legal index and a non-zero size
    a_r8_mw_legal: assert property (@(posedge clk) disable iff (!rst_n)
        q.mwu |-> (int'(q.mwi) < NUM_MW) && (q.mws != '0));

    // R12: parameter words do not move across the busy cycle
    a_r12_busy_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == ST_BUSY |=> $stable(q.arg) && $stable(q.size) && $stable(q.alo));
endmodule

// File: rtl/hl_link_join.sv
module hl_link_join import hl_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NHOST-1:0] req,
    output logic [NHOST-1:0] up,
    output logic [NHOST-1:0] evt
);
    typedef struct packed {
        logic [NHOST-1:0] up;
        logic [NHOST-1:0] evt;
    } join_t;

    join_t q, d;

    always_comb begin
        d.up  = q.up | req;
        d.evt = ((&d.up) && !(&q.up)) ? '1 : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign up  = q.up;
    assign evt = q.evt;

    // R10: an event only appears with both hosts up
    a_r10_evt_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        q.evt != '0 |-> (&q.up));

    // R10: the event is a single-cycle pulse
    a_r10_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.evt != '0 |=> q.evt == '0);

    // R11: flags never drop once set
    a_r11_up_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.up != '0 |=> ((q.up & $past(q.up)) == $past(q.up)));
endmodule

// File: rtl/hostlink_cmd_ctrl.sv
module hostlink_cmd_ctrl import hl_pkg::*; #(
    parameter int            NUM_MW   = 4,
    parameter int            MW_IW    = (NUM_MW > 1) ? $clog2(NUM_MW) : 1,
    parameter logic [DW-1:0] TOPO_UP  = 32'd1,
    parameter logic [DW-1:0] TOPO_DN  = 32'd2,
    parameter logic [DW-1:0] MW1_OFS  = 32'h1000,
    parameter logic [DW-1:0] SPAD_OFS = 32'hC0,
    parameter logic [DW-1:0] SPAD_CNT = 32'd16,
    parameter logic [DW-1:0] DB_ENTRY = 32'd4,
    parameter logic [DW-1:0] DB_BASE  = 32'h00D0_0000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NHOST-1:0]              reg_wr,
    input  logic [NHOST-1:0]              reg_rd,
    input  logic [NHOST-1:0][AW-1:0]      reg_addr,
    input  logic [NHOST-1:0][DW-1:0]      reg_wdata,
    output logic [NHOST-1:0][DW-1:0]      reg_rdata,
    output logic [NHOST-1:0][DBC_W-1:0]   db_count,
    output logic [NHOST-1:0]              db_msix,
    output logic [NHOST-1:0]              mw_upd,
    output logic [NHOST-1:0][MW_IW-1:0]   mw_index,
    output logic [NHOST-1:0][2*DW-1:0]    mw_addr,
    output logic [NHOST-1:0][DW-1:0]      mw_size,
    output logic [NHOST-1:0]              link_up,
    output logic [NHOST-1:0]              link_evt
);
    logic [NHOST-1:0] link_req;

    for (genvar h = 0; h < NHOST; h++) begin : g_host
        hl_host_regs #(
            .HOST_ID   (h),
            .NUM_MW    (NUM_MW),
            .MW_IW     (MW_IW),
            .TOPO_CODE ((h == 0) ? TOPO_UP : TOPO_DN),
            .MW1_OFS   (MW1_OFS),
            .SPAD_OFS  (SPAD_OFS),
            .SPAD_CNT  (SPAD_CNT),
            .DB_ENTRY  (DB_ENTRY),
            .DB_BASE   (DB_BASE)
        ) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (reg_wr[h]),
            .rd       (reg_rd[h]),
            .addr     (reg_addr[h]),
            .wdata    (reg_wdata[h]),
            .rdata    (reg_rdata[h]),
            .db_count (db_count[h]),
            .db_msix  (db_msix[h]),
            .mw_upd   (mw_upd[h]),
            .mw_index (mw_index[h]),
            .mw_addr  (mw_addr[h]),
            .mw_size  (mw_size[h]),
            .link_req (link_req[h])
        );
    end

    hl_link_join u_join (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (link_req),
        .up    (link_up),
        .evt   (link_evt)
    );
endmodule

// File: tb/sim_hostlink_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_hostlink_cmd_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [1:0]        reg_wr = '0, reg_rd = '0;
    logic [1:0][5:0]   reg_addr = '0;
    logic [1:0][31:0]  reg_wdata = '0;
    logic [1:0][31:0]  reg_rdata;
    logic [1:0][5:0]   db_count;
    logic [1:0]        db_msix, mw_upd, link_up, link_evt;
    logic [1:0][1:0]   mw_index;
    logic [1:0][63:0]  mw_addr;
    logic [1:0][31:0]  mw_size;

    int checks = 0;
    int failures = 0;
    int evt_cnt [2] = '{0, 0};

    hostlink_cmd_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .db_count(db_count), .db_msix(db_msix), .mw_upd(mw_upd),
        .mw_index(mw_index), .mw_addr(mw_addr), .mw_size(mw_size),
        .link_up(link_up), .link_evt(link_evt)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (link_evt[0]) evt_cnt[0]++;
            if (link_evt[1]) evt_cnt[1]++;
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(int h, int a, logic [31:0] v);
        @(negedge clk);
        reg_wr[h] = 1'b1; reg_addr[h] = 6'(a); reg_wdata[h] = v;
        @(negedge clk);
        reg_wr[h] = 1'b0;
    endtask

    task automatic rd(int h, int a, output logic [31:0] v);
        @(negedge clk);
        reg_rd[h] = 1'b1; reg_addr[h] = 6'(a);
        @(negedge clk);
        reg_rd[h] = 1'b0;
        v = reg_rdata[h];
    endtask

    // issues a command, samples pulses in the completion cycle, returns status
    task automatic cmd(int h, logic [31:0] op, output logic pulse,
                       output logic [1:0] evt, output logic [31:0] st);
        logic [31:0] c;
        wr(h, 0, op);
        @(negedge clk);
        pulse = mw_upd[h];
        evt = link_evt;
        rd(h, 2, st);
        rd(h, 0, c);
        chk("R4 command word cleared", c, 0);
    endtask

    initial begin
        logic [31:0] v, st;
        logic p;
        logic [1:0] e;
        int exp_cnt [2];
        logic exp_x [2];
        logic [1:0] exp_mi [2];
        logic [63:0] exp_ma [2];
        logic [31:0] exp_ms [2];

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int h = 0; h < 2; h++) begin
            for (int a = 0; a < 7; a++) begin
                if (a == 3) continue;
                rd(h, a, v);
                chk("R1 reset word", v, 0);
            end
            chk("R1 reset db_count", db_count[h], 0);
            chk("R1 reset db_msix", db_msix[h], 0);
            chk("R1 reset mw_size", mw_size[h], 0);
            chk("R1 reset mw_addr", mw_addr[h], 0);
        end
        chk("R1 reset link_up", link_up, 0);

        // R3 constant words, before and after write attempts
        for (int h = 0; h < 2; h++) begin
            for (int pass = 0; pass < 2; pass++) begin
                rd(h, 3, v);  chk("R3 topology", v, (h == 0) ? 1 : 2);
                rd(h, 7, v);  chk("R3 window count", v, 4);
                rd(h, 8, v);  chk("R3 window1 offset", v, 32'h1000);
                rd(h, 9, v);  chk("R3 spad offset", v, 32'hC0);
                rd(h, 10, v); chk("R3 spad count", v, 16);
                rd(h, 11, v); chk("R3 db entry size", v, 4);
                for (int a = 2; a < 12; a++)
                    if (a == 2 || a == 3 || a >= 7) wr(h, a, 32'hFFFF_FFFF);
            end
            rd(h, 2, v); chk("R3 status not writable", v, 0);
        end

        // R2 read-write words, per host independence
        for (int h = 0; h < 2; h++)
            for (int a = 4; a <= 6; a++)
                wr(h, a, 32'h1000_0000 * (h + 1) + 32'(a * 17));
        for (int h = 0; h < 2; h++)
            for (int a = 4; a <= 6; a++) begin
                rd(h, a, v);
                chk("R2 readback", v, 32'h1000_0000 * (h + 1) + 32'(a * 17));
            end
        wr(0, 1, 32'hCAFE_0001); wr(1, 1, 32'h0BAD_0002);
        rd(0, 1, v); chk("R2 arg host0", v, 32'hCAFE_0001);
        rd(1, 1, v); chk("R2 arg host1", v, 32'h0BAD_0002);

        // R5 / R6 doorbell sweep
        for (int h = 0; h < 2; h++) begin
            exp_cnt[h] = 0; exp_x[h] = 1'b0;
            for (int c = 0; c <= 34; c++) begin
                logic [31:0] arg;
                bit good;
                arg = (c == 34) ? 32'h0001_FFFF : ((32'(c & 1) << 16) | 32'(c));
                good = (c <= 32);
                wr(h, 1, arg);
                cmd(h, 32'd1, p, e, st);
                chk(good ? "R5 doorbell status" : "R6 doorbell status", st, good ? 2 : 3);
                if (good) begin exp_cnt[h] = c; exp_x[h] = c[0]; end
                chk("R5 R6 db_count", db_count[h], 64'(exp_cnt[h]));
                chk("R5 R6 db_msix", db_msix[h], exp_x[h]);
                for (int i = 0; i < 32; i++) begin
                    rd(h, 12 + i, v);
                    chk("R5 R6 doorbell data", v,
                        (i < exp_cnt[h]) ? (32'h00D0_0000 + 32'(h * 256) + 32'(i)) : 0);
                end
            end
        end

        // R7 / R8 window sweep
        for (int h = 0; h < 2; h++) begin
            exp_mi[h] = 0; exp_ma[h] = 0; exp_ms[h] = 0;
            for (int idx = 0; idx <= 4; idx++)
                for (int z = 0; z < 2; z++) begin
                    logic [31:0] lo, hi, sz;
                    bit good;
                    lo = 32'hA000_0000 | 32'(h << 8) | 32'(idx);
                    hi = 32'h5500_0000 + 32'(idx * 3 + z);
                    sz = (z == 0) ? 0 : 32'h40 * 32'(idx + 1);
                    good = (idx < 4) && (z == 1);
                    wr(h, 4, lo); wr(h, 5, hi); wr(h, 6, sz); wr(h, 1, 32'(idx));
                    cmd(h, 32'd2, p, e, st);
                    chk(good ? "R7 window status" : "R8 window status", st, good ? 2 : 3);
                    chk(good ? "R7 update pulse" : "R8 no update pulse", p, good);
                    if (good) begin
                        exp_mi[h] = 2'(idx); exp_ma[h] = {hi, lo}; exp_ms[h] = sz;
                    end
                    chk("R7 R8 mw_index", mw_index[h], exp_mi[h]);
                    chk("R7 R8 mw_addr", mw_addr[h], exp_ma[h]);
                    chk("R7 R8 mw_size", mw_size[h], exp_ms[h]);
                end
        end

        // R9 unknown codes
        foreach (e[k]) ;
        for (int k = 0; k < 3; k++) begin
            logic [31:0] op;
            op = (k == 0) ? 32'd4 : (k == 1) ? 32'hFF : 32'h8000_0001;
            cmd(0, op, p, e, st);
            chk("R9 unknown code error", st, 3);
            chk("R9 no pulse", p, 0);
            chk("R9 db unchanged", db_count[0], 64'(exp_cnt[0]));
            chk("R9 link unchanged", link_up, 0);
        end

        // R12 write during busy cycle ignored
        wr(0, 4, 32'h1234_5678); wr(0, 5, 32'h9); wr(0, 6, 32'h80); wr(0, 1, 32'd3);
        @(negedge clk);
        reg_wr[0] = 1'b1; reg_addr[0] = 6'd0; reg_wdata[0] = 32'd2;
        @(negedge clk);
        reg_addr[0] = 6'd1; reg_wdata[0] = 32'd0;
        @(negedge clk);
        reg_wr[0] = 1'b0;
        chk("R12 window update from first command", mw_upd[0], 1);
        rd(0, 1, v); chk("R12 arg write in busy cycle ignored", v, 3);
        rd(0, 2, v); chk("R12 status success", v, 2);
        chk("R12 mw_index", mw_index[0], 3);
        chk("R12 db unchanged", db_count[0], 64'(exp_cnt[0]));

        // R10 / R11 link handshake
        cmd(0, 32'd3, p, e, st);
        chk("R10 host0 link status", st, 2);
        chk("R10 one host no event", e, 0);
        chk("R10 host0 flag", link_up, 2'b01);
        cmd(0, 32'd3, p, e, st);
        chk("R11 repeat before join no event", e, 0);
        cmd(1, 32'd3, p, e, st);
        chk("R10 both hosts event", e, 2'b11);
        chk("R10 both flags", link_up, 2'b11);
        cmd(1, 32'd3, p, e, st);
        chk("R11 repeat after join no event", e, 0);
        cmd(0, 32'd3, p, e, st);
        chk("R11 link status success", st, 2);
        repeat (5) @(negedge clk);
        chk("R11 flags held", link_up, 2'b11);
        chk("R10 R11 host0 event count", evt_cnt[0], 1);
        chk("R10 R11 host1 event count", evt_cnt[1], 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule